// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

This block is an all-digital quadrature oscillator. A 32-bit phase register advances on every clock by a frequency tuning word. A run-time phase offset is added to it, and the sum is truncated to a 12-bit angle. That angle becomes a pair of 12-bit signed samples, one sine and one cosine. An 8-bit amplitude word then scales both samples. Changing the tuning word, the offset or the amplitude from cycle to cycle gives frequency, phase and quadrature amplitude modulation.

The angle-to-amplitude table covers only the first eighth of a turn. The top three angle bits pick the octant. In odd octants the remaining bits are complemented, so the table is read backwards. The table has two read ports that return the sine and the cosine of the folded angle. The octant bits then decide whether the two values are exchanged and which of them is negated. The result is both full waveforms across all eight octants.

Top module: `quad_dds_nco`

## Requirements
- R1: While rst_ni is low, sin_o and cos_o are 0 and the phase register is cleared.
- R2: The phase register adds ftw_i on each rising clock edge. A new tuning word changes the phase step at the next edge, and holding ftw_i at 0 freezes the phase.
- R3: poff_i is added to the phase register before truncation. The angle used is bits [31:20] of (phase + poff_i) mod 2^32.
- R4: Two rising edges after they are sampled, sin_o and cos_o equal round(amp/256 * 2047 * sin(2*pi*p/2^32)) and the matching cosine, where p is the offset phase. The tolerance is 1 LSB plus the truncation bound of 2047*pi/4096*amp/256.
- R5: Angle bits [11:9] are the octant. When bit 9 is 1, bits [8:0] are complemented before the table is read. The table entry at address a holds sin and cos of (a+0.5)*pi/2048, so its sine never exceeds its cosine.
- R6: Sine and cosine are exchanged in octants 1, 2, 5 and 6. The sine is negative only in octants 4 to 7. The cosine is negative only in octants 2 to 5.
- R7: Each output is round-half-up of (value * amp_i) / 256, with amp_i unsigned. amp_i = 0 gives exactly 0, and no output magnitude exceeds (2047*amp_i + 128) >> 8.
- R8: A tuning word of 2^31, which is half the clock rate, is accepted and gives outputs that follow R4.
- R9: Before scaling, sin^2 + cos^2 stays within 2 LSB of 2047 in radius.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ftw_i | input | 32 | Frequency tuning word, added to the phase every clock |
| poff_i | input | 32 | Phase offset, added before truncation |
| amp_i | input | 8 | Unsigned amplitude scale, value/256 |
| sin_o | output | 12 | Signed sine sample |
| cos_o | output | 12 | Signed cosine sample |

## Verification
The assertions check on every cycle the per-octant relations:
- the table's sine never exceeds its cosine;
- the output signs follow the octant;
- the unscaled pair stays near the unit circle;
- zero amplitude gives zero, and every output stays within its amplitude bound;
- a zero tuning word freezes the phase.

The bench runs a behavioural phase model against a real-valued sine and cosine on every clock. Only these scenarios can show the rest:
- the latency of a tuning word change;
- the offset shifting the angle;
- the correct octant placement of every sample;
- rounding of the scale;
- operation at the half-rate tuning word.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef struct packed {
    logic swap;
    logic neg_s;
    logic neg_c;
  } oct_ctl_t;

  function automatic oct_ctl_t oct_decode(input logic [2:0] oct);
    oct_ctl_t c;
    c.swap  = oct[0] ^ oct[1];
    c.neg_s = oct[2];
    c.neg_c = oct[1] ^ oct[2];
    return c;
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int TRUNC_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] ftw_i,
  input  logic [PHASE_W-1:0] poff_i,
  output logic [TRUNC_W-1:0] ph_o
);
  localparam int SHIFT = PHASE_W - TRUNC_W;

  logic [PHASE_W-1:0] acc_q, sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + ftw_i;
  end

  assign sum  = acc_q + poff_i;
  assign ph_o = TRUNC_W'(sum >> SHIFT);

  p_hold_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ftw_i == '0) |=> $stable(acc_q));
endmodule

// File: rtl/dds_octant_lut.sv
module dds_octant_lut
  import dds_pkg::*;
#(
  parameter int OUT_W   = 12,
  parameter int TRUNC_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TRUNC_W-1:0]      ph_i,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  localparam int  ADDR_W = TRUNC_W - 3;
  localparam int  DEPTH  = 1 << ADDR_W;
  localparam int  MAXV   = (1 << (OUT_W - 1)) - 1;
  localparam int  R_LO   = (MAXV - 2) * (MAXV - 2);
  localparam int  R_HI   = (MAXV + 2) * (MAXV + 2);
  localparam real PI     = 3.14159265358979;

  logic [OUT_W-2:0] tab_s [DEPTH];
  logic [OUT_W-2:0] tab_c [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    localparam real ANG = (real'(i) + 0.5) * PI / (4.0 * real'(DEPTH));
    localparam int  SV  = int'(real'(MAXV) * $sin(ANG));
    localparam int  CV  = int'(real'(MAXV) * $cos(ANG));
    assign tab_s[i] = (OUT_W-1)'(SV);
    assign tab_c[i] = (OUT_W-1)'(CV);
  end

  logic [2:0]        oct;
  logic [ADDR_W-1:0] addr;
  oct_ctl_t          ctl;
  logic [OUT_W-2:0]  mag_s, mag_c, a_s, a_c;
  logic signed [OUT_W-1:0] v_s, v_c;

  assign oct   = ph_i[TRUNC_W-1 -: 3];
  assign addr  = oct[0] ? ~ph_i[ADDR_W-1:0] : ph_i[ADDR_W-1:0];
  assign ctl   = oct_decode(oct);
  assign mag_s = tab_s[addr];
  assign mag_c = tab_c[addr];
  assign a_s   = ctl.swap ? mag_c : mag_s;
  assign a_c   = ctl.swap ? mag_s : mag_c;
  assign v_s   = ctl.neg_s ? -$signed({1'b0, a_s}) : $signed({1'b0, a_s});
  assign v_c   = ctl.neg_c ? -$signed({1'b0, a_c}) : $signed({1'b0, a_c});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= v_s;
      cos_o <= v_c;
    end
  end

  p_first_octant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_s <= mag_c);
  p_sine_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oct[2] == 1'b0) |=> (sin_o >= 0));
  p_cosine_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((oct[1] ^ oct[2]) == 1'b0) |=> (cos_o >= 0));
  p_unit_circle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |->
      ((int'(sin_o) * int'(sin_o) + int'(cos_o) * int'(cos_o)) >= R_LO &&
       (int'(sin_o) * int'(sin_o) + int'(cos_o) * int'(cos_o)) <= R_HI));
endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
  parameter int OUT_W = 12,
  parameter int AMP_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [OUT_W-1:0] val_i,
  input  logic [AMP_W-1:0]        amp_i,
  output logic signed [OUT_W-1:0] out_o
);
  localparam int PW   = OUT_W + AMP_W + 1;
  localparam int MAXV = (1 << (OUT_W - 1)) - 1;
  localparam int HALF = 1 << (AMP_W - 1);

  logic signed [PW-1:0] v_ext, a_ext, prod, rnd;

  assign v_ext = PW'(val_i);
  assign a_ext = $signed(PW'(amp_i));
  assign prod  = v_ext * a_ext;
  assign rnd   = (prod + PW'(HALF)) >>> AMP_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= '0;
    else         out_o <= rnd[OUT_W-1:0];
  end

  p_zero_amp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_i == '0) |=> (out_o == '0));
  p_amp_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_o < 0) ? -int'(out_o) : int'(out_o))
      <= ((MAXV * int'($past(amp_i)) + HALF) >> AMP_W));
endmodule

// File: rtl/quad_dds_nco.sv
module quad_dds_nco #(
  parameter int PHASE_W = 32,
  parameter int TRUNC_W = 12,
  parameter int OUT_W   = 12,
  parameter int AMP_W   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PHASE_W-1:0]      ftw_i,
  input  logic [PHASE_W-1:0]      poff_i,
  input  logic [AMP_W-1:0]        amp_i,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o
);
  logic [TRUNC_W-1:0]      ph;
  logic [AMP_W-1:0]        amp_q;
  logic signed [OUT_W-1:0] raw [2];
  logic signed [OUT_W-1:0] scl [2];

  dds_phase_acc #(.PHASE_W(PHASE_W), .TRUNC_W(TRUNC_W)) u_acc (
    .clk_i, .rst_ni, .ftw_i, .poff_i, .ph_o(ph)
  );

  dds_octant_lut #(.OUT_W(OUT_W), .TRUNC_W(TRUNC_W)) u_lut (
    .clk_i, .rst_ni, .ph_i(ph), .sin_o(raw[0]), .cos_o(raw[1])
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_q <= '0;
    else         amp_q <= amp_i;
  end

  for (genvar k = 0; k < 2; k++) begin : g_ch
    dds_amp_scale #(.OUT_W(OUT_W), .AMP_W(AMP_W)) u_scale (
      .clk_i, .rst_ni, .val_i(raw[k]), .amp_i(amp_q), .out_o(scl[k])
    );
  end

  assign sin_o = scl[0];
  assign cos_o = scl[1];

  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (sin_o == '0 && cos_o == '0));
endmodule

// File: tb/quad_dds_nco_bench.sv
module quad_dds_nco_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ftw = '0, poff = '0;
  logic [7:0]  amp = '0;
  logic signed [11:0] sin_o, cos_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  real   q_s[$], q_c[$], q_t[$];
  string q_r[$];
  logic [31:0] acc_m = '0;

  localparam real PI = 3.14159265358979;

  always #4 clk = ~clk;

  quad_dds_nco u_quad_dds_nco (
    .clk_i(clk), .rst_ni(rst_n), .ftw_i(ftw), .poff_i(poff), .amp_i(amp),
    .sin_o(sin_o), .cos_o(cos_o)
  );

  // behavioural model: one entry per edge, visible after the next edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_m = '0;
      q_s.delete(); q_c.delete(); q_t.delete(); q_r.delete();
    end else begin
      logic [31:0] p;
      real ang, sc;
      p   = acc_m + poff;
      ang = 2.0 * PI * real'(p) / 4294967296.0;
      sc  = real'(amp) / 256.0;
      q_s.push_back(2047.0 * sc * $sin(ang));
      q_c.push_back(2047.0 * sc * $cos(ang));
      q_t.push_back(amp == 0 ? 0.01 : 1.01 + 2047.0 * PI / 4096.0 * sc);
      q_r.push_back(cur_req);
      acc_m = acc_m + ftw;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done && q_s.size() >= 2) begin
      real es, ec, t;
      string r;
      es = q_s.pop_front(); ec = q_c.pop_front();
      t  = q_t.pop_front(); r  = q_r.pop_front();
      n_chk++;
      if ((real'(sin_o) - es > t) || (es - real'(sin_o) > t) ||
          (real'(cos_o) - ec > t) || (ec - real'(cos_o) > t)) begin
        n_bad++;
        $display("FAIL %s: sin=%0d cos=%0d expected sin=%0.2f cos=%0.2f (tol %0.2f)",
                 r, sin_o, cos_o, es, ec, t);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fin;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    fin();
  end

  initial begin
    // R1: outputs held at zero during reset
    amp = 8'd255; ftw = 32'h0100_0000;
    run(4);
    n_chk++;
    if (sin_o !== 12'sd0 || cos_o !== 12'sd0) begin
      n_bad++;
      $display("FAIL R1: sin=%0d cos=%0d expected 0/0", sin_o, cos_o);
    end
    rst_n = 1'b1;
    // R4, R5, R6: slow sweep through every octant at full scale
    cur_req = "R4";
    ftw = 32'h0080_0000; run(600);
    cur_req = "R5";
    ftw = 32'h0013_57ab; run(500);
    // R2: tuning word steps, including zero (frozen phase)
    cur_req = "R2";
    ftw = 32'h0000_0000; run(20);
    ftw = 32'h1234_5678; run(30);
    ftw = 32'h0fed_cba9; run(30);
    // R3: phase offset jumps
    cur_req = "R3";
    ftw = 32'h0040_0000;
    for (int i = 0; i < 8; i++) begin
      poff = 32'h2000_0000 * i + 32'h0123_4567; run(10);
    end
    poff = '0;
    // R7: amplitude steps, including zero and small values
    cur_req = "R7";
    for (int i = 0; i < 9; i++) begin
      amp = (i == 8) ? 8'd255 : 8'(i * 32); run(40);
    end
    amp = 8'd0;  run(20);
    amp = 8'd1;  run(20);
    amp = 8'd200; run(20);
    // R8: half-rate tuning word
    cur_req = "R8";
    ftw = 32'h8000_0000; poff = 32'h1000_0000; run(40);
    // R6, R9: fast mixed modulation across octants
    cur_req = "R6";
    ftw = 32'h2f00_0001; amp = 8'd255; run(60);
    cur_req = "R9";
    for (int i = 0; i < 40; i++) begin
      ftw = 32'h0777_0000 * i; poff = 32'h0abc_0000 * i; amp = 8'(255 - i);
      run(3);
    end
    // R1: asynchronous reset in mid-run clears outputs
    cur_req = "R1";
    @(posedge clk); #1 rst_n = 1'b0;
    #2;
    n_chk++;
    if (sin_o !== 12'sd0 || cos_o !== 12'sd0) begin
      n_bad++;
      $display("FAIL R1: sin=%0d cos=%0d expected 0/0 after reset", sin_o, cos_o);
    end
    run(2);
    fin();
  end
endmodule